// File: doc/BRIEF.md
# Keyed Stall-Injection Lock Unit

This block sits on an existing pipeline stall line and decides whether the design behind it runs at full throughput. It watches a data bus for one secret trigger value. When that value appears and the applied key is wrong, the block raises the stall in that same cycle. It then enters a timed hold that keeps the stall high for a fixed number of further cycles, so no useful work is done. When the key is right, the block restores the stall to its original value on the trigger cycle. It never enters the hold, and the downstream logic sees exactly the stall it would have seen without the block.

The output stall is built from two paths joined by an XOR. The perturb path ORs the trigger detection into the original stall. The restore path compares each bus bit with the matching key bit and flips the perturbed stall back only when the key is correct and the trigger is present. Only the low `KEY_W` bits of the bus take part in the comparisons, and the upper bits are don't-cares. The correct key is therefore the low `KEY_W` bits of the trigger parameter. A small controller counts out the hold period.

Top module: `stall_lock_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the block unlocked with its hold counter cleared, so the first cycle after reset passes `stallIn` to `stallOut` for a non-trigger bus value.
- R2: While not in the hold and while `dataIn[KEY_W-1:0]` differs from `TRIGGER[KEY_W-1:0]`, `stallOut` equals `stallIn` in the same cycle.
- R3: When `dataIn[KEY_W-1:0]` equals `TRIGGER[KEY_W-1:0]` and `keyIn` differs from `TRIGGER[KEY_W-1:0]`, `stallOut` is 1 in that same cycle, whatever `stallIn` is.
- R4: When the trigger is present and `keyIn` equals `TRIGGER[KEY_W-1:0]`, `stallOut` equals `stallIn`, and no hold follows.
- R5: A wrong-key trigger seen while not in the hold starts the hold. `stallOut` is then 1 for exactly `LOCK_CYCLES` consecutive cycles after the trigger cycle. After that the block is unlocked again.
- R6: A trigger arriving during the hold, with any key, neither restarts nor lengthens the hold.
- R7: Changing `keyIn` to the correct key during the hold does not shorten it.
- R8: Bits `dataIn[IN_W-1:KEY_W]` have no effect on trigger detection or on the key comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | IN_W | Watched data bus |
| keyIn | input | KEY_W | Applied key, sampled every cycle |
| stallIn | input | 1 | Original stall from the host design |
| stallOut | output | 1 | Stall delivered to the host design |

## Verification
The combinational result (R2, R3, R4, R8) is due in the very cycle its stimulus is applied. The bench therefore drives on the falling edge and samples one nanosecond later, before the next rising edge. The hold starts at the rising edge that ends a wrong-key trigger cycle and covers the next `LOCK_CYCLES` sampled cycles. The bench keeps an arithmetic countdown that is loaded at that edge and decremented at each later edge, and it compares every sample against it. A full sweep of every key, bus value and stall value on a three-bit key gives each trigger case in and out of the hold. Directed sequences re-trigger the hold and switch to the correct key mid-hold to check that its length stays fixed.

// File: rtl/stall_lock_pkg.sv
package stall_lock_pkg;

  typedef enum logic {
    ST_NORMAL = 1'b0,
    ST_LOCK   = 1'b1
  } lockState_t;

  // datapath -> control
  typedef struct packed {
    logic trigHit;
    logic keyMatch;
  } matchInfo_t;

  // control -> datapath
  typedef struct packed {
    logic holdStall;
  } ctrlStrobe_t;

endpackage

// File: rtl/stall_lock_dp.sv
module stall_lock_dp
  import stall_lock_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int KEY_W = 6,
  parameter logic [IN_W-1:0] TRIGGER = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   dataIn,
  input  logic [KEY_W-1:0]  keyIn,
  input  logic              stallIn,
  input  ctrlStrobe_t       ctrl,
  output matchInfo_t        info,
  output logic              stallOut
);

  logic [KEY_W-1:0] trigBits;
  logic [KEY_W-1:0] keyBits;
  logic trigHit;
  logic inKeyEq;
  logic perturbed;
  logic restore;

  // per-bit comparators; only the low KEY_W bus bits take part
  for (genvar i = 0; i < KEY_W; i++) begin : g_cmp
    assign trigBits[i] = ~(dataIn[i] ^ TRIGGER[i]);
    assign keyBits[i]  = ~(dataIn[i] ^ keyIn[i]);
  end

  assign trigHit = &trigBits;
  assign inKeyEq = &keyBits;

  // perturb path forces the stall on the trigger
  assign perturbed = stallIn | trigHit;
  // restore path flips it back only where perturb changed it
  assign restore   = trigHit & inKeyEq & ~stallIn;

  assign stallOut = ctrl.holdStall | (perturbed ^ restore);

  assign info.trigHit  = trigHit;
  assign info.keyMatch = inKeyEq;

  assert_wrong_key_stall_R3: assert property (@(posedge clk) disable iff (rst)
    (info.trigHit && !info.keyMatch) |-> stallOut);

  assert_hold_forces_stall_R5: assert property (@(posedge clk) disable iff (rst)
    ctrl.holdStall |-> stallOut);

  assert_transparent_R2_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.holdStall && (!info.trigHit || info.keyMatch)) |-> (stallOut == stallIn));

endmodule

// File: rtl/stall_lock_ctrl.sv
module stall_lock_ctrl
  import stall_lock_pkg::*;
#(
  parameter int LOCK_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  matchInfo_t  info,
  output ctrlStrobe_t ctrl
);

  localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES - 1);

  lockState_t       state;
  logic [CNT_W-1:0] cnt;
  logic             launch;
  logic             cntZero;

  assign cntZero = (cnt == '0);
  assign launch  = (state == ST_NORMAL) && info.trigHit && !info.keyMatch;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_NORMAL;
      cnt   <= '0;
    end else begin
      case (state)
        ST_NORMAL: begin
          if (launch) begin
            state <= ST_LOCK;
            cnt   <= CNT_LOAD;
          end
        end
        ST_LOCK: begin
          if (cntZero) begin
            state <= ST_NORMAL;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_NORMAL;
      endcase
    end
  end

  assign ctrl.holdStall = (state == ST_LOCK);

  assert_launch_load_R5: assert property (@(posedge clk) disable iff (rst)
    launch |=> (state == ST_LOCK && cnt == CNT_LOAD));

  assert_no_restart_R6_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && !cntZero) |=> (state == ST_LOCK && cnt == $past(cnt) - 1'b1));

  assert_lock_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK && cntZero) |=> (state == ST_NORMAL));

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (state == ST_NORMAL && cntZero));

endmodule

// File: rtl/stall_lock_unit.sv
module stall_lock_unit
  import stall_lock_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int KEY_W = 6,
  parameter logic [IN_W-1:0] TRIGGER = 8'hA5,
  parameter int LOCK_CYCLES = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  dataIn,
  input  logic [KEY_W-1:0] keyIn,
  input  logic             stallIn,
  output logic             stallOut
);

  matchInfo_t  info;
  ctrlStrobe_t ctrl;

  stall_lock_dp #(
    .IN_W(IN_W), .KEY_W(KEY_W), .TRIGGER(TRIGGER)
  ) dp_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .keyIn(keyIn),
    .stallIn(stallIn), .ctrl(ctrl), .info(info), .stallOut(stallOut)
  );

  stall_lock_ctrl #(
    .LOCK_CYCLES(LOCK_CYCLES)
  ) ctrl_i (
    .clk(clk), .rst(rst), .info(info), .ctrl(ctrl)
  );

endmodule

// File: tb/stall_lock_unit_tb.sv
module stall_lock_unit_tb_top;

  localparam int IN_W = 4;
  localparam int KEY_W = 3;
  localparam logic [IN_W-1:0] TRIGGER = 4'b1011;
  localparam int LOCK_CYCLES = 5;
  localparam logic [KEY_W-1:0] GOOD_KEY = 3'b011;
  localparam logic [KEY_W-1:0] BAD_KEY  = 3'b110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0]  dataIn = '0;
  logic [KEY_W-1:0] keyIn = '0;
  logic stallIn = 1'b0;
  logic stallOut;

  int total = 0;
  int bad = 0;
  int lockRem = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  stall_lock_unit #(
    .IN_W(IN_W), .KEY_W(KEY_W), .TRIGGER(TRIGGER), .LOCK_CYCLES(LOCK_CYCLES)
  ) dut_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .keyIn(keyIn),
    .stallIn(stallIn), .stallOut(stallOut)
  );

  function automatic bit isTrig(input logic [IN_W-1:0] d);
    return d[KEY_W-1:0] == TRIGGER[KEY_W-1:0];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: stallOut=%0b expected=%0b (data=%0h key=%0h stallIn=%0b)",
               req, act, exp, dataIn, keyIn, stallIn);
    end
  endtask

  // one cycle: drive after falling edge, sample before rising edge, update model at the edge
  task automatic step(input logic [IN_W-1:0] d, input logic [KEY_W-1:0] k,
                      input logic s, input string tag);
    logic exp;
    bit trig;
    bit wrongKey;
    @(negedge clk);
    dataIn = d; keyIn = k; stallIn = s;
    #1;
    trig = isTrig(d);
    wrongKey = (k != GOOD_KEY);
    exp = (lockRem > 0) || s || (trig && wrongKey);
    if (tag != "") check(tag, stallOut, exp);
    else if (lockRem > 0) check("R5", stallOut, exp);
    else if (trig && wrongKey) check("R3", stallOut, exp);
    else if (trig) check("R4", stallOut, exp);
    else check("R2", stallOut, exp);
    @(posedge clk);
    if (lockRem > 0) lockRem--;
    else if (trig && wrongKey) lockRem = LOCK_CYCLES;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    lockRem = 0;
  endtask

  initial begin
    doReset();
    // R1: unlocked after reset, stall passes straight through
    step(4'h0, BAD_KEY, 1'b0, "R1");
    step(4'h0, BAD_KEY, 1'b1, "R1");

    // exhaustive sweep of key, bus and stall with the arithmetic model
    for (int k = 0; k < 8; k++) begin
      for (int d = 0; d < 16; d++) begin
        for (int s = 0; s < 2; s++) begin
          step(IN_W'(d), KEY_W'(k), s[0], "");
        end
      end
    end

    // R5: exact hold length after a wrong-key trigger
    doReset();
    step(TRIGGER, BAD_KEY, 1'b0, "R3");
    for (int i = 0; i < LOCK_CYCLES; i++) step(4'h0, BAD_KEY, 1'b0, "R5");
    step(4'h0, BAD_KEY, 1'b0, "R5");   // hold over, expected 0

    // R6: re-trigger inside the hold does not extend it
    doReset();
    step(TRIGGER, BAD_KEY, 1'b0, "R3");
    step(4'h0, BAD_KEY, 1'b0, "R5");
    step(TRIGGER, 3'b000, 1'b0, "R6");
    step(TRIGGER, BAD_KEY, 1'b0, "R6");
    for (int i = 0; i < LOCK_CYCLES - 3; i++) step(4'h0, BAD_KEY, 1'b0, "R6");
    step(4'h0, BAD_KEY, 1'b0, "R6");   // back to 0 exactly on time

    // R7: correct key mid-hold does not shorten it
    doReset();
    step(TRIGGER, BAD_KEY, 1'b0, "R3");
    for (int i = 0; i < LOCK_CYCLES; i++) step(4'h1, GOOD_KEY, 1'b0, "R7");
    step(4'h1, GOOD_KEY, 1'b0, "R7");

    // R4: correct key on the trigger never stalls or locks
    doReset();
    for (int i = 0; i < 6; i++) step(TRIGGER, GOOD_KEY, 1'b0, "R4");
    step(TRIGGER, GOOD_KEY, 1'b1, "R4");

    // R8: upper bus bit is a don't-care for both paths
    doReset();
    step(4'b0011, GOOD_KEY, 1'b0, "R8");
    step(4'b0011, BAD_KEY, 1'b0, "R8");
    for (int i = 0; i < LOCK_CYCLES; i++) step(4'b1000, BAD_KEY, 1'b0, "R8");
    step(4'b1000, BAD_KEY, 1'b0, "R8");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule